// File: doc/BRIEF.md
# NAND Command, Address and Data Port Adapter

This block sits behind a chip-select's register group. It turns a CPU register access of 1, 2 or 4 bytes into a short run of NAND bus cycles. Three 4-byte register slots form the port: one for commands, one for addresses and one for data. A write to the command slot drives each bus cycle with the command-latch line high. A write to the address slot drives the address-latch line high instead. Data-slot accesses drive neither line.

The number of bus cycles depends on the access size and on the device width. The device width is read from the chip-select's configuration word. Writes cut the CPU word into device-sized pieces, lowest piece first. Reads collect one piece per cycle into a single response word.

The CPU side has a request/ready handshake. The adapter latches the request when it is idle. Each bus cycle holds its strobe high for `STROBE_CLKS` clocks, then low for the same number of clocks. A one-clock ready pulse ends the access.

The controller has four states:
- `ST_IDLE` waits for a request.
- `ST_STROBE` holds the read or write strobe.
- `ST_GAP` holds the recovery time after a strobe.
- `ST_DONE` presents the response.

Transitions:
- IDLE to STROBE on a request that needs bus cycles.
- IDLE to DONE on a request that needs none.
- STROBE to GAP when the phase timer expires.
- GAP to STROBE when more pieces remain.
- GAP to DONE after the last piece.
- DONE to IDLE always.

Top module: `nand_port_adapter`

## Requirements
- R1: Offsets decode in 4-byte slots: 0x7C–0x7F is the command slot, 0x80–0x83 the address slot, 0x84–0x87 the data slot. A read of the command or address slot returns 0 and makes no bus cycle.
- R2: During every cycle of a command write `nand_cle` is high and `nand_ale` low. During every cycle of an address write `nand_ale` is high and `nand_cle` low. Data cycles and read cycles drive both low. `nand_cle` and `nand_ale` are never high together.
- R3: For an 8-bit device, `req_size` 0, 1 and 2 (or 3) mean 1, 2 and 4 bytes and make 1, 2 and 4 cycles. A write sends byte k of `req_wdata` on `nand_dout[7:0]` in cycle k, with `nand_dout[15:8]` at 0. A read places `nand_din[7:0]` of cycle k in byte k of the response.
- R4: For a 16-bit device, a 2-byte access makes one cycle and a 4-byte access makes two. Half k of the word goes in cycle k, low half first, for both writes and reads.
- R5: On a 16-bit device, a 1-byte read makes one cycle and returns only `nand_din[7:0]` in the low byte, zero elsewhere. A 1-byte write makes one cycle that sends `req_wdata[15:0]`.
- R6: The device width is bit 12 of `cs_cfg` (1 = 16-bit). Bit 13 has no effect.
- R7: The device type is `cs_cfg[11:10]`, and 2'b10 means NAND. For any other type, port writes make no cycle and reads return 0.
- R8: A 1- or 2-byte access to an offset outside 0x7C–0x87 makes no cycle and completes with `resp_err` high. A 4-byte access there completes without error and returns 0.
- R9: `resp_ready` is a one-clock pulse. An access needing n cycles shows ready 2·`STROBE_CLKS`·n+1 clocks after the edge that accepts it. The request is latched at acceptance, so later changes on the request inputs have no effect on that access.
- R10: Each strobe is high for exactly `STROBE_CLKS` clocks and is followed by `STROBE_CLKS` low clocks. The read and write strobes are never high together.
- R11: During and after reset, all strobes, `nand_cle`, `nand_ale` and `resp_ready` are low, including when reset cuts an access short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | Register offset within the chip-select group |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | WORD_W | Write data |
| cs_cfg | input | CFG_W | Chip-select configuration word (type bits 11:10, width bit 12) |
| resp_ready | output | 1 | One-clock completion pulse |
| resp_rdata | output | WORD_W | Read word, valid with ready |
| resp_err | output | 1 | Width error, valid with ready |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wr_stb | output | 1 | Write strobe, active high |
| nand_rd_stb | output | 1 | Read strobe, active high |
| nand_dout | output | DEV_W | Data to the device |
| nand_din | input | DEV_W | Data from the device |

## Verification
Inputs change on the falling clock edge, and outputs are sampled on the falling edge too. The bench counts falling edges from the drive to the ready pulse. It compares that count with 2·`STROBE_CLKS`·n+1, where n comes from the access size and the device-width bit. Accesses that need no cycles are due on the first falling edge.

A device model records `nand_dout`, `nand_cle` and `nand_ale` at the first falling edge of each strobe. At that same edge it presents the next read value on `nand_din`. The value therefore stays stable until the adapter samples it on the last strobe clock.

// File: rtl/nand_port_pkg.sv
package nand_port_pkg;

    typedef enum logic [1:0] {
        RK_CMD   = 2'd0,
        RK_ADDR  = 2'd1,
        RK_DATA  = 2'd2,
        RK_OTHER = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2,
        ST_DONE   = 2'd3
    } adp_state_e;

    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_HALF  = 2'd1;
    localparam logic [1:0] DEV_NAND = 2'b10;
    localparam int         TYPE_LSB = 10;
    localparam int         WIDE_BIT = 12;

    // number of device cycles for an access size and device width
    function automatic logic [2:0] pieces_for(input logic [1:0] size, input logic wide);
        logic [2:0] n;
        if (wide) begin
            n = (size == SZ_BYTE || size == SZ_HALF) ? 3'd1 : 3'd2;
        end else begin
            unique case (size)
                SZ_BYTE: n = 3'd1;
                SZ_HALF: n = 3'd2;
                default: n = 3'd4;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/nand_reg_decode.sv
module nand_reg_decode
    import nand_port_pkg::*;
#(
    parameter int               OFS_W     = 8,
    parameter logic [OFS_W-1:0] CMD_BASE  = 8'h7C,
    parameter logic [OFS_W-1:0] ADDR_BASE = 8'h80,
    parameter logic [OFS_W-1:0] DATA_BASE = 8'h84
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    output reg_kind_e        kind,
    output logic             narrow_err
);

    localparam int NSLOT = 3;
    localparam logic [OFS_W-1:0] SLOT_BASE [NSLOT] = '{CMD_BASE, ADDR_BASE, DATA_BASE};

    logic [NSLOT-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_slot
            assign hit[g] = (ofs[OFS_W-1:2] == SLOT_BASE[g][OFS_W-1:2]);
        end
    endgenerate

    always_comb begin
        if (hit[0])      kind = RK_CMD;
        else if (hit[1]) kind = RK_ADDR;
        else if (hit[2]) kind = RK_DATA;
        else             kind = RK_OTHER;
    end

    assign narrow_err = (size == SZ_BYTE || size == SZ_HALF) && (kind == RK_OTHER);

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int PHASE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);

    localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

    logic [CW-1:0] cnt_q;

    assign phase_end = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/nand_read_gather.sv
module nand_read_gather #(
    parameter int WORD_W = 32,
    parameter int DEV_W  = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wide,
    input  logic              byte_only,
    input  logic [DEV_W-1:0]  din,
    output logic [WORD_W-1:0] word
);

    localparam int NLANE = WORD_W / 8;

    genvar b;
    generate
        for (b = 0; b < NLANE; b++) begin : g_lane
            logic       take;
            logic [7:0] lane_d;
            logic [7:0] lane_q;

            always_comb begin
                if (!wide) begin
                    take   = capture && (int'(idx) == b);
                    lane_d = din[7:0];
                end else if (byte_only) begin
                    take   = capture && (b == 0);
                    lane_d = din[7:0];
                end else begin
                    take   = capture && (int'(idx) == (b / 2));
                    lane_d = ((b % 2) == 0) ? din[7:0] : din[15:8];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    lane_q <= 8'h00;
                end else if (take) begin
                    lane_q <= lane_d;
                end
            end

            assign word[8*b +: 8] = lane_q;
        end
    endgenerate

endmodule

// File: rtl/nand_port_adapter.sv
module nand_port_adapter
    import nand_port_pkg::*;
#(
    parameter int               OFS_W       = 8,
    parameter int               WORD_W      = 32,
    parameter int               DEV_W       = 16,
    parameter int               CFG_W       = 32,
    parameter int               STROBE_CLKS = 2,
    parameter logic [OFS_W-1:0] CMD_BASE    = 8'h7C,
    parameter logic [OFS_W-1:0] ADDR_BASE   = 8'h80,
    parameter logic [OFS_W-1:0] DATA_BASE   = 8'h84
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [1:0]        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [CFG_W-1:0]  cs_cfg,
    output logic              resp_ready,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              resp_err,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_wr_stb,
    output logic              nand_rd_stb,
    output logic [DEV_W-1:0]  nand_dout,
    input  logic [DEV_W-1:0]  nand_din
);

    localparam int IDX_W = $clog2(WORD_W / 8);
    localparam int TOT_W = IDX_W + 1;

    adp_state_e        state_q, state_d;
    reg_kind_e         dec_kind, kind_q;
    logic              dec_narrow;
    logic              wr_q, wide_q, byte16_q, err_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TOT_W-1:0]  total_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] gather_word;
    logic [DEV_W-1:0]  piece;
    logic              is_nand, cfg_wide, cfg_unused;
    logic              accept, needs_cycles, busy, phase_end, last_piece;

    // configuration word fields
    assign is_nand    = (cs_cfg[TYPE_LSB +: 2] == DEV_NAND);
    assign cfg_wide   = cs_cfg[WIDE_BIT];
    assign cfg_unused = ^{cs_cfg[CFG_W-1:WIDE_BIT+1], cs_cfg[TYPE_LSB-1:0]};

    nand_reg_decode #(
        .OFS_W    (OFS_W),
        .CMD_BASE (CMD_BASE),
        .ADDR_BASE(ADDR_BASE),
        .DATA_BASE(DATA_BASE)
    ) u_decode (
        .ofs       (req_offset),
        .size      (req_size),
        .kind      (dec_kind),
        .narrow_err(dec_narrow)
    );

    assign accept       = (state_q == ST_IDLE) && req_valid;
    assign needs_cycles = !dec_narrow && (dec_kind != RK_OTHER) && is_nand
                          && (req_write || dec_kind == RK_DATA);
    assign busy         = (state_q == ST_STROBE) || (state_q == ST_GAP);
    assign last_piece   = ({1'b0, idx_q} == (total_q - 1'b1));

    nand_phase_timer #(
        .PHASE_CLKS(STROBE_CLKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .phase_end(phase_end)
    );

    nand_read_gather #(
        .WORD_W(WORD_W),
        .DEV_W (DEV_W),
        .IDX_W (IDX_W)
    ) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .capture  ((state_q == ST_STROBE) && phase_end && !wr_q),
        .idx      (idx_q),
        .wide     (wide_q),
        .byte_only(byte16_q),
        .din      (nand_din),
        .word     (gather_word)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = needs_cycles ? ST_STROBE : ST_DONE;
            ST_STROBE: if (phase_end) state_d = ST_GAP;
            ST_GAP:    if (phase_end) state_d = last_piece ? ST_DONE : ST_STROBE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and piece index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            kind_q   <= RK_OTHER;
            wide_q   <= 1'b0;
            byte16_q <= 1'b0;
            err_q    <= 1'b0;
            total_q  <= '0;
            idx_q    <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            wr_q     <= req_write;
            kind_q   <= dec_kind;
            wide_q   <= cfg_wide;
            byte16_q <= cfg_wide && (req_size == SZ_BYTE);
            err_q    <= dec_narrow;
            total_q  <= TOT_W'(pieces_for(req_size, cfg_wide));
            idx_q    <= '0;
            wdata_q  <= req_wdata;
        end else if ((state_q == ST_GAP) && phase_end && !last_piece) begin
            idx_q    <= idx_q + 1'b1;
        end
    end

    // write piece selection
    always_comb begin
        piece = '0;
        if (wide_q) begin
            piece[15:0] = wdata_q[{idx_q[0], 4'b0000} +: 16];
        end else begin
            piece[7:0]  = wdata_q[{idx_q, 3'b000} +: 8];
        end
    end

    // outputs
    always_comb begin
        nand_wr_stb = (state_q == ST_STROBE) && wr_q;
        nand_rd_stb = (state_q == ST_STROBE) && !wr_q;
        nand_cle    = busy && (kind_q == RK_CMD);
        nand_ale    = busy && (kind_q == RK_ADDR);
        nand_dout   = (busy && wr_q) ? piece : '0;
        resp_ready  = (state_q == ST_DONE);
        resp_err    = (state_q == ST_DONE) && err_q;
        resp_rdata  = (state_q == ST_DONE) ? gather_word : '0;
    end

endmodule

// File: rtl/nand_port_adapter_chk.sv
module nand_port_adapter_chk #(
    parameter int STROBE_CLKS = 2
) (
    input logic clk,
    input logic rst_n,
    input logic resp_ready,
    input logic resp_err,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_wr_stb,
    input logic nand_rd_stb
);

    logic       stb_any;
    logic [15:0] run_len;

    assign stb_any = nand_wr_stb || nand_rd_stb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (stb_any) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R2
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R2
    rd_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_rd_stb |-> (!nand_cle && !nand_ale));

    // R2
    latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_wr_stb && $past(nand_wr_stb)) |-> ($stable(nand_cle) && $stable(nand_ale)));

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_wr_stb && nand_rd_stb));

    // R10
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_any) |-> (run_len == 16'(STROBE_CLKS)));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready |=> !resp_ready);

    // R9
    ready_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready |-> (!stb_any && !nand_cle && !nand_ale));

    // R8
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_ready);

endmodule

bind nand_port_adapter nand_port_adapter_chk #(
    .STROBE_CLKS(STROBE_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .resp_ready (resp_ready),
    .resp_err   (resp_err),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_wr_stb(nand_wr_stb),
    .nand_rd_stb(nand_rd_stb)
);

// File: tb/tb_nand_port_adapter.sv
`timescale 1ns/1ps
module tb_nand_port_adapter;

    localparam int S  = 2;
    localparam int NV = 23;

    typedef struct packed {
        logic        wr;
        logic [7:0]  ofs;
        logic [1:0]  size;
        logic [15:0] cfg;
        logic [31:0] wdata;
        logic [2:0]  n;
        logic        cle;
        logic        ale;
        logic        err;
        logic [31:0] rdata;
    } vec_t;

    // cfg: bits 11:10 type (10 = NAND), bit 12 width, bit 13 ignored
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h7C, 2'd0, 16'h0800, 32'h000000FF, 3'd1, 1'b1, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h81, 2'd2, 16'h0800, 32'h12345678, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0},
        '{1'b1, 8'h84, 2'd1, 16'h0800, 32'h0000ABCD, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h86, 2'd2, 16'h1800, 32'hDEADBEEF, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h7F, 2'd1, 16'h1800, 32'h00003090, 3'd1, 1'b1, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h84, 2'd0, 16'h1800, 32'h0000A55A, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h84, 2'd2, 16'h0800, 32'h0,        3'd4, 1'b0, 1'b0, 1'b0, 32'h23222120},
        '{1'b0, 8'h85, 2'd1, 16'h0800, 32'h0,        3'd2, 1'b0, 1'b0, 1'b0, 32'h00002120},
        '{1'b0, 8'h84, 2'd2, 16'h1800, 32'h0,        3'd2, 1'b0, 1'b0, 1'b0, 32'hB121B020},
        '{1'b0, 8'h84, 2'd0, 16'h1800, 32'h0,        3'd1, 1'b0, 1'b0, 1'b0, 32'h00000020},
        '{1'b0, 8'h84, 2'd1, 16'h1800, 32'h0,        3'd1, 1'b0, 1'b0, 1'b0, 32'h0000B020},
        '{1'b0, 8'h87, 2'd3, 16'h2800, 32'h0,        3'd4, 1'b0, 1'b0, 1'b0, 32'h23222120},
        '{1'b1, 8'h84, 2'd2, 16'h2800, 32'h01020304, 3'd4, 1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h7C, 2'd0, 16'h0400, 32'h000000AA, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h84, 2'd2, 16'h0000, 32'h0,        3'd0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h80, 2'd1, 16'h3C00, 32'h0000FFFF, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h60, 2'd0, 16'h0800, 32'h00000011, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0},
        '{1'b0, 8'h78, 2'd1, 16'h0800, 32'h0,        3'd0, 1'b0, 1'b0, 1'b1, 32'h0},
        '{1'b0, 8'h60, 2'd2, 16'h0800, 32'h0,        3'd0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 8'h88, 2'd0, 16'h0800, 32'h00000055, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0},
        '{1'b1, 8'h7B, 2'd1, 16'h0800, 32'h00000066, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0},
        '{1'b0, 8'h7C, 2'd2, 16'h0800, 32'h0,        3'd0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 8'h83, 2'd1, 16'h0800, 32'h0,        3'd0, 1'b0, 1'b0, 1'b0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_offset;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic [31:0] cs_cfg;
    logic        resp_ready, resp_err;
    logic [31:0] resp_rdata;
    logic        nand_cle, nand_ale, nand_wr_stb, nand_rd_stb;
    logic [15:0] nand_dout;
    logic [15:0] nand_din = 16'h0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    nand_port_adapter #(.STROBE_CLKS(S)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .cs_cfg(cs_cfg), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
        .resp_err(resp_err), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_wr_stb(nand_wr_stb), .nand_rd_stb(nand_rd_stb),
        .nand_dout(nand_dout), .nand_din(nand_din)
    );

    always #4 clk = ~clk;

    // device model: log each cycle at the first falling edge of its strobe
    int          pieces_seen = 0;
    int          acc_start   = 0;
    logic        wr_prev = 1'b0, rd_prev = 1'b0;
    logic [15:0] log_dout [16];
    logic        log_cle  [16];
    logic        log_ale  [16];

    always @(negedge clk) begin
        int k;
        k = pieces_seen - acc_start;
        if ((nand_wr_stb && !wr_prev) || (nand_rd_stb && !rd_prev)) begin
            if (k >= 0 && k < 16) begin
                log_dout[k] = nand_dout;
                log_cle[k]  = nand_cle;
                log_ale[k]  = nand_ale;
            end
            if (nand_rd_stb) nand_din = {8'hB0 + 8'(k), 8'h20 + 8'(k)};
            pieces_seen = pieces_seen + 1;
        end
        wr_prev = nand_wr_stb;
        rd_prev = nand_rd_stb;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_piece(input vec_t t, input int i);
        if (t.cfg[12]) return (t.size == 2'd0) ? t.wdata[15:0] : t.wdata[16*i +: 16];
        return {8'h00, t.wdata[8*i +: 8]};
    endfunction

    // mutate: change the request inputs while the access is in flight
    task automatic do_access(input vec_t t, input bit mutate);
        int lat;
        int base;
        bit got;
        logic [31:0] rd;
        logic er;
        acc_start  = pieces_seen;
        base       = pieces_seen;
        req_valid  = 1'b1;
        req_write  = t.wr;
        req_offset = t.ofs;
        req_size   = t.size;
        req_wdata  = t.wdata;
        cs_cfg     = {16'h0, t.cfg};
        lat = 0; got = 0; rd = '0; er = 1'b0;
        while (!got && lat < 400) begin
            @(negedge clk);
            lat++;
            if (mutate && lat == 3) begin
                req_write  = ~t.wr;
                req_offset = 8'h7C;
                req_size   = 2'd0;
                req_wdata  = 32'h11111111;
                cs_cfg     = 32'h0000_1800;
            end
            if (resp_ready) begin
                got = 1;
                rd  = resp_rdata;
                er  = resp_err;
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(lat == 2*S*int'(t.n) + 1, "R9 ready latency", lat, 2*S*int'(t.n) + 1);
        chk(pieces_seen - base == int'(t.n), "R3 R4 R5 R7 R8 cycle count",
            pieces_seen - base, t.n);
        chk(er == t.err, "R8 error flag", er, t.err);
        if (!t.wr) chk(rd == t.rdata, "R1 R3 R4 R5 R7 read word", rd, t.rdata);
        for (int i = 0; i < int'(t.n); i++) begin
            chk(log_cle[i] == t.cle && log_ale[i] == t.ale, "R1 R2 latch lines",
                {log_cle[i], log_ale[i]}, {t.cle, t.ale});
            if (t.wr) chk(log_dout[i] == exp_piece(t, i),
                          t.cfg[12] ? "R4 R5 write piece" : "R3 R6 write piece",
                          log_dout[i], exp_piece(t, i));
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_offset = '0;
        req_size = '0; req_wdata = '0; cs_cfg = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!nand_wr_stb && !nand_rd_stb && !nand_cle && !nand_ale && !resp_ready,
            "R11 reset outputs", {nand_wr_stb, nand_rd_stb, nand_cle, nand_ale, resp_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) do_access(VECS[v], 1'b0);

        // R9: request inputs changed mid-access must not affect it
        do_access('{1'b1, 8'h80, 2'd2, 16'h0800, 32'hCAFEF00D, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0}, 1'b1);
        do_access('{1'b0, 8'h84, 2'd2, 16'h1800, 32'h0, 3'd2, 1'b0, 1'b0, 1'b0, 32'hB121B020}, 1'b1);

        // R11: reset in the middle of an access
        req_valid = 1'b1; req_write = 1'b1; req_offset = 8'h7C; req_size = 2'd2;
        req_wdata = 32'h0; cs_cfg = 32'h0000_0800;
        repeat (3) @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk(!nand_wr_stb && !nand_rd_stb && !nand_cle && !nand_ale && !resp_ready,
            "R11 outputs after mid-access reset",
            {nand_wr_stb, nand_rd_stb, nand_cle, nand_ale, resp_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_access(VECS[1], 1'b0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule